// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block runs once after reset. It reads a configuration image from a serial EEPROM one byte at a time and turns it into 32-bit register writes. Each byte comes through a simple request/acknowledge handshake, so the serial bus engine stays outside the block.

The image is a chain of typed blocks. A sequential block gives a 14-bit system address, a count of 32-bit words, and then the words themselves. Each word is written to the next 4-byte-aligned address. A terminating block closes the image.

Every byte read, the terminating block included, goes into an 8-bit running sum that must come to all ones. A mismatch raises a checksum error unless the `ignoreCsum` input is high. An unknown block type stops the load at once and raises a type error.

Top module: `cfg_rom_loader`

## Requirements
- R1: The first byte requested is at EEPROM address 0. `romReq` stays high with `romAddr` held until `romAck` arrives, and each accepted byte moves `romAddr` up by exactly one.
- R2: In the first header byte, bits [1:0] are the block type and bits [7:2] are system address bits [7:2]. Address bits [1:0] are always zero. In the second header byte, bits [5:0] are address bits [13:8], and bits [7:6] have no effect.
- R3: The third and fourth header bytes form the 16-bit word count, low byte first. A block with a count of zero issues no write, and the byte after it is read as a new header.
- R4: Each data word arrives least significant byte first. It is written by a one-cycle `regWrEn` pulse. The first word goes to the block address and each later word to the previous address plus 4, wrapping within 14 bits.
- R5: Type 2'b01 is a sequential block. Type 2'b11 is a two-byte terminating block, and reading stops after its second byte.
- R6: The 8-bit sum of all bytes read, both terminating bytes included, must be 8'hFF. If it is not, `csumErr` is set when `done` rises.
- R7: While `ignoreCsum` is high, a wrong sum does not set `csumErr`, and the load still completes with `done`.
- R8: Type 2'b00 or 2'b10 in a header ends the load right after that byte. `typeErr` and `done` are set, `csumErr` stays low, and no further bytes are requested.
- R9: `busy` is high and `done` low from reset until the load ends. After that, `done` stays high, `busy` stays low, and `romReq` stays low.
- R10: A word's write pulse can fall in the same cycle as the next byte's acceptance. Neither one waits, so with an acknowledge every cycle the load takes at most four cycles more than the number of bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ignoreCsum | input | 1 | Suppresses the checksum error flag |
| romReq | output | 1 | Byte read request |
| romAddr | output | ROM_AW | EEPROM byte address of the request |
| romAck | input | 1 | Byte returned this cycle |
| romData | input | 8 | Returned byte, valid with romAck |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrAddr | output | 14 | System byte address of the write |
| regWrData | output | 32 | Write data |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load finished (held) |
| csumErr | output | 1 | Checksum mismatch at the end of the load |
| typeErr | output | 1 | Unknown block type ended the load |

## Verification
The write of a finished data word is issued one cycle after its fourth byte is accepted. In that same cycle the loader can accept the next image byte, whether that byte is data, a header or a terminating byte. The bench provokes this by acknowledging every cycle while `romReq` is high. It then judges the result in three ways. The write log must match the slow-acknowledge run word for word, the checksum verdict must be unchanged, and the load must end within the byte count plus four cycles.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  localparam int SYS_AW = 14;

  typedef enum logic [1:0] {
    BLK_RSV0 = 2'b00,
    BLK_SEQ  = 2'b01,
    BLK_RSV2 = 2'b10,
    BLK_END  = 2'b11
  } blkType_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic take;
    logic ldAddrLo;
    logic ldAddrHi;
    logic ldCntLo;
    logic ldCntHi;
    logic ldLane;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    blkType_e byteType;
    logic     cntZeroNow;
    logic     laneLast;
    logic     lastWord;
    logic     sumOk;
  } dpSts_t;

endpackage

// File: rtl/cfgld_dp.sv
module cfgld_dp
  import cfgld_pkg::*;
#(
  parameter int ROM_AW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  output dpSts_t            sts,
  input  logic [7:0]        romData,
  output logic [ROM_AW-1:0] romAddr,
  output logic              regWrEn,
  output logic [SYS_AW-1:0] regWrAddr,
  output logic [31:0]       regWrData
);

  localparam logic [SYS_AW-1:0] WORD_STEP = SYS_AW'(4);

  logic [ROM_AW-1:0] romAddrQ;
  logic [SYS_AW-1:0] blkAddrQ;
  logic [15:0]       cntQ;
  logic [1:0]        laneQ;
  logic [31:0]       wordQ;
  logic [7:0]        sumQ;
  logic              wrEnQ;
  logic [SYS_AW-1:0] wrAddrQ;
  logic [31:0]       wrDataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romAddrQ <= '0;
      blkAddrQ <= '0;
      cntQ     <= '0;
      laneQ    <= '0;
      wordQ    <= '0;
      sumQ     <= '0;
      wrEnQ    <= 1'b0;
      wrAddrQ  <= '0;
      wrDataQ  <= '0;
    end else begin
      wrEnQ <= 1'b0;
      if (ctl.clrAll) begin
        romAddrQ <= '0;
        sumQ     <= '0;
        laneQ    <= '0;
      end
      if (ctl.take) begin
        romAddrQ <= romAddrQ + 1'b1;
        sumQ     <= sumQ + romData;
      end
      if (ctl.ldAddrLo) blkAddrQ[7:0] <= {romData[7:2], 2'b00};
      if (ctl.ldAddrHi) blkAddrQ[SYS_AW-1:8] <= romData[SYS_AW-9:0];
      if (ctl.ldCntLo) cntQ[7:0] <= romData;
      if (ctl.ldCntHi) begin
        cntQ[15:8] <= romData;
        laneQ      <= '0;
      end
      if (ctl.ldLane) begin
        wordQ <= {romData, wordQ[31:8]};
        laneQ <= laneQ + 1'b1;
        if (laneQ == 2'd3) begin
          wrEnQ    <= 1'b1;
          wrAddrQ  <= blkAddrQ;
          wrDataQ  <= {romData, wordQ[31:8]};
          blkAddrQ <= blkAddrQ + WORD_STEP;
          cntQ     <= cntQ - 1'b1;
        end
      end
    end
  end

  always_comb begin
    sts.byteType   = blkType_e'(romData[1:0]);
    sts.cntZeroNow = ({romData, cntQ[7:0]} == 16'd0);
    sts.laneLast   = (laneQ == 2'd3);
    sts.lastWord   = (cntQ == 16'd1);
    sts.sumOk      = (sumQ == 8'hFF);
  end

  assign romAddr   = romAddrQ;
  assign regWrEn   = wrEnQ;
  assign regWrAddr = wrAddrQ;
  assign regWrData = wrDataQ;

  // a write never repeats on the next cycle: a word needs four bytes
  assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEnQ |=> !wrEnQ);

  // written addresses are word aligned
  assert_wr_align_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEnQ |-> (wrAddrQ[1:0] == 2'b00));

  // control never feeds a data byte into a block with nothing left
  assert_no_data_past_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldLane |-> (cntQ != 16'd0));

endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   romAck,
  input  logic   ignoreCsum,
  input  dpSts_t sts,
  output dpCtl_t ctl,
  output logic   romReq,
  output logic   busy,
  output logic   done,
  output logic   csumErr,
  output logic   typeErr
);

  typedef enum logic [1:0] {ST_START, ST_FETCH, ST_CHECK, ST_END} state_e;
  typedef enum logic [2:0] {PH_HDR0, PH_HDR1, PH_CNT0, PH_CNT1, PH_DATA, PH_TAIL} phase_e;

  state_e stQ;
  phase_e phQ;
  logic   busyQ, doneQ, csumErrQ, typeErrQ;
  logic   accept;

  assign romReq = (stQ == ST_FETCH);
  assign accept = romReq && romAck;

  always_comb begin
    ctl        = '0;
    ctl.clrAll = (stQ == ST_START);
    ctl.take   = accept;
    if (accept) begin
      case (phQ)
        PH_HDR0: ctl.ldAddrLo = 1'b1;
        PH_HDR1: ctl.ldAddrHi = 1'b1;
        PH_CNT0: ctl.ldCntLo  = 1'b1;
        PH_CNT1: ctl.ldCntHi  = 1'b1;
        PH_DATA: ctl.ldLane   = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ      <= ST_START;
      phQ      <= PH_HDR0;
      busyQ    <= 1'b1;
      doneQ    <= 1'b0;
      csumErrQ <= 1'b0;
      typeErrQ <= 1'b0;
    end else begin
      case (stQ)
        ST_START: begin
          stQ <= ST_FETCH;
          phQ <= PH_HDR0;
        end
        ST_FETCH: if (accept) begin
          case (phQ)
            PH_HDR0: begin
              case (sts.byteType)
                BLK_SEQ: phQ <= PH_HDR1;
                BLK_END: phQ <= PH_TAIL;
                default: begin
                  stQ      <= ST_END;
                  typeErrQ <= 1'b1;
                  doneQ    <= 1'b1;
                  busyQ    <= 1'b0;
                end
              endcase
            end
            PH_HDR1: phQ <= PH_CNT0;
            PH_CNT0: phQ <= PH_CNT1;
            PH_CNT1: phQ <= sts.cntZeroNow ? PH_HDR0 : PH_DATA;
            PH_DATA: if (sts.laneLast && sts.lastWord) phQ <= PH_HDR0;
            PH_TAIL: stQ <= ST_CHECK;
            default: phQ <= PH_HDR0;
          endcase
        end
        ST_CHECK: begin
          stQ      <= ST_END;
          doneQ    <= 1'b1;
          busyQ    <= 1'b0;
          csumErrQ <= !ignoreCsum && !sts.sumOk;
        end
        default: ;
      endcase
    end
  end

  assign busy    = busyQ;
  assign done    = doneQ;
  assign csumErr = csumErrQ;
  assign typeErr = typeErrQ;

  assert_busy_not_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    busyQ != doneQ);

  assert_done_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> doneQ);

  assert_no_read_after_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !romReq);

  assert_ignore_masks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_CHECK && ignoreCsum) |=> !csumErrQ);

  assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(csumErrQ && typeErrQ));

  assert_err_implies_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (csumErrQ || typeErrQ) |-> doneQ);

endmodule

// File: rtl/cfg_rom_loader.sv
module cfg_rom_loader
  import cfgld_pkg::*;
#(
  parameter int ROM_AW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ignoreCsum,
  output logic              romReq,
  output logic [ROM_AW-1:0] romAddr,
  input  logic              romAck,
  input  logic [7:0]        romData,
  output logic              regWrEn,
  output logic [13:0]       regWrAddr,
  output logic [31:0]       regWrData,
  output logic              busy,
  output logic              done,
  output logic              csumErr,
  output logic              typeErr
);

  dpCtl_t ctl;
  dpSts_t sts;

  cfgld_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .romAck    (romAck),
    .ignoreCsum(ignoreCsum),
    .sts       (sts),
    .ctl       (ctl),
    .romReq    (romReq),
    .busy      (busy),
    .done      (done),
    .csumErr   (csumErr),
    .typeErr   (typeErr)
  );

  cfgld_dp #(.ROM_AW(ROM_AW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .sts      (sts),
    .romData  (romData),
    .romAddr  (romAddr),
    .regWrEn  (regWrEn),
    .regWrAddr(regWrAddr),
    .regWrData(regWrData)
  );

  // address advances by one per accepted byte and holds otherwise
  assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (romReq && romAck) |=> (romAddr == $past(romAddr) + 1'b1));

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (romReq && !romAck) |=> (romAddr == $past(romAddr)));

endmodule

// File: tb/cfg_rom_loader_bench.sv
module cfg_rom_loader_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ignoreCsum = 1'b0;
  logic        romReq;
  logic [15:0] romAddr;
  logic        romAck = 1'b0;
  logic [7:0]  romData = 8'h00;
  logic        regWrEn;
  logic [13:0] regWrAddr;
  logic [31:0] regWrData;
  logic        busy, done, csumErr, typeErr;

  always #5 clk = ~clk;

  cfg_rom_loader u_cfg_rom_loader (
    .clk(clk), .rstN(rstN), .ignoreCsum(ignoreCsum),
    .romReq(romReq), .romAddr(romAddr), .romAck(romAck), .romData(romData),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .busy(busy), .done(done), .csumErr(csumErr), .typeErr(typeErr)
  );

  int checks = 0;
  int fails  = 0;

  // image and expectations
  logic [7:0]  mem [256];
  int          wp;
  logic [7:0]  runSum;
  logic [13:0] expAddr [64];
  logic [31:0] expData [64];
  int          expN;

  // observations
  logic [13:0] logAddr [64];
  logic [31:0] logData [64];
  int          logN;
  int          ackCount;
  int          firstAddr;
  bit          fastMode = 1'b0;
  int          waitCnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // byte responder
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && romReq && (fastMode || waitCnt >= 2)) begin
        if (ackCount == 0) firstAddr = int'(romAddr);
        romAck   = 1'b1;
        romData  = mem[romAddr[7:0]];
        ackCount = ackCount + 1;
        waitCnt  = 0;
      end else begin
        romAck  = 1'b0;
        romData = 8'hEE;
        if (rstN && romReq) waitCnt = waitCnt + 1;
        else waitCnt = 0;
      end
    end
  end

  // write logger
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && regWrEn) begin
        if (logN < 64) begin
          logAddr[logN] = regWrAddr;
          logData[logN] = regWrData;
        end
        logN = logN + 1;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WDOG", "run time limit", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic newImage();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    wp = 0; runSum = 8'h00; expN = 0;
  endtask

  task automatic putB(input logic [7:0] b);
    mem[wp] = b;
    runSum  = runSum + b;
    wp      = wp + 1;
  endtask

  function automatic logic [31:0] dataOf(input int k);
    return 32'h1122_3344 ^ (32'(k) * 32'h0103_0507) ^ 32'h8000_00F0;
  endfunction

  task automatic seqBlk(input logic [13:0] addr, input int n, input logic [1:0] junk);
    logic [15:0] n16;
    logic [31:0] w;
    n16 = 16'(n);
    putB({addr[7:2], 2'b01});
    putB({junk, addr[13:8]});
    putB(n16[7:0]);
    putB(n16[15:8]);
    for (int i = 0; i < n; i++) begin
      w = dataOf(expN);
      expAddr[expN] = addr + 14'(4 * i);
      expData[expN] = w;
      expN = expN + 1;
      putB(w[7:0]); putB(w[15:8]); putB(w[23:16]); putB(w[31:24]);
    end
  endtask

  task automatic endBlk(input bit corrupt);
    logic [7:0] fix;
    putB(8'h5F);
    fix = 8'hFF - runSum;
    if (corrupt) fix = fix ^ 8'h01;
    putB(fix);
  endtask

  task automatic stdImage(input bit corrupt);
    newImage();
    seqBlk(14'h0100, 3, 2'b00);
    seqBlk(14'h0800, 0, 2'b11);
    seqBlk(14'h3FFC, 2, 2'b10);
    endBlk(corrupt);
  endtask

  task automatic startRun(input bit fast, input bit ign);
    rstN = 1'b0;
    fastMode = fast;
    ignoreCsum = ign;
    logN = 0; ackCount = 0; firstAddr = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitDone(output int cyc);
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R9", "done reached", 32'(done), 32'd1);
    repeat (3) @(negedge clk);
  endtask

  task automatic cmpWrites(input string req);
    chk(logN == expN, req, "write count", 32'(logN), 32'(expN));
    for (int i = 0; i < expN && i < logN; i++) begin
      chk(logAddr[i] == expAddr[i], req, "write addr", 32'(logAddr[i]), 32'(expAddr[i]));
      chk(logData[i] == expData[i], req, "write data", logData[i], expData[i]);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R9", "busy in reset", 32'(busy), 32'd1);
    chk(done == 1'b0, "R9", "done in reset", 32'(done), 32'd0);
    chk(romReq == 1'b0, "R9", "romReq in reset", 32'(romReq), 32'd0);
    chk(regWrEn == 1'b0, "R4", "regWrEn in reset", 32'(regWrEn), 32'd0);
  endtask

  task automatic t_basic();
    int cyc;
    stdImage(1'b0);
    startRun(1'b0, 1'b0);
    @(negedge clk);
    chk(busy == 1'b1, "R9", "busy after release", 32'(busy), 32'd1);
    waitDone(cyc);
    chk(firstAddr == 0, "R1", "first address", 32'(firstAddr), 32'd0);
    chk(ackCount == wp, "R5", "bytes read", 32'(ackCount), 32'(wp));
    cmpWrites("R4");
    chk(csumErr == 1'b0, "R6", "csumErr on good sum", 32'(csumErr), 32'd0);
    chk(typeErr == 1'b0, "R8", "typeErr on good image", 32'(typeErr), 32'd0);
    chk(busy == 1'b0, "R9", "busy at end", 32'(busy), 32'd0);
    chk(romReq == 1'b0, "R9", "romReq at end", 32'(romReq), 32'd0);
    // R2 junk in second header byte, R3 zero-count block: covered by write list
    chk(logN > 3 && logAddr[3] == 14'h3FFC, "R2", "addr with junk high bits", 32'(logAddr[3]), 32'h3FFC);
    chk(logN > 4 && logAddr[4] == 14'h0000, "R4", "address wrap", 32'(logAddr[4]), 32'h0);
    chk(logN == 5, "R3", "zero-count block writes nothing", 32'(logN), 32'd5);
  endtask

  task automatic t_fast();
    int cyc;
    stdImage(1'b0);
    startRun(1'b1, 1'b0);
    waitDone(cyc);
    cmpWrites("R10");
    chk(cyc <= wp + 4, "R10", "cycles at full rate", 32'(cyc), 32'(wp + 4));
    chk(csumErr == 1'b0, "R10", "csumErr at full rate", 32'(csumErr), 32'd0);
    chk(ackCount == wp, "R10", "bytes read at full rate", 32'(ackCount), 32'(wp));
  endtask

  task automatic t_badsum();
    int cyc;
    stdImage(1'b1);
    startRun(1'b0, 1'b0);
    waitDone(cyc);
    chk(csumErr == 1'b1, "R6", "csumErr on bad sum", 32'(csumErr), 32'd1);
    chk(typeErr == 1'b0, "R6", "typeErr on bad sum", 32'(typeErr), 32'd0);
    cmpWrites("R6");
  endtask

  task automatic t_ignore();
    int cyc;
    stdImage(1'b1);
    startRun(1'b1, 1'b1);
    waitDone(cyc);
    chk(csumErr == 1'b0, "R7", "csumErr masked", 32'(csumErr), 32'd0);
    chk(done == 1'b1 && busy == 1'b0, "R7", "load completes", 32'({done, busy}), 32'b10);
  endtask

  task automatic t_badtype(input logic [7:0] badHdr, input bit withBlock);
    int cyc;
    int expReads;
    newImage();
    if (withBlock) seqBlk(14'h0040, 1, 2'b00);
    expReads = wp + 1;
    putB(badHdr);
    putB(8'h01); putB(8'h00); putB(8'h01); putB(8'h00);
    startRun(1'b0, 1'b0);
    waitDone(cyc);
    chk(typeErr == 1'b1, "R8", "typeErr", 32'(typeErr), 32'd1);
    chk(csumErr == 1'b0, "R8", "csumErr on type stop", 32'(csumErr), 32'd0);
    chk(ackCount == expReads, "R8", "reads stop at bad header", 32'(ackCount), 32'(expReads));
    cmpWrites("R8");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_fast();
    t_badsum();
    t_ignore();
    t_badtype(8'h42, 1'b1);
    t_badtype(8'h00, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule